// File: doc/BRIEF.md
# Disk Request Command-Block Generator

This block turns one linear disk request into the command blocks a disk controller needs. A request names a start block, a sector count, a direction, a drive number and the start address of its data buffer. The drive geometry (head count, cylinder count, sectors per track) and a per-drive control byte come in on static inputs. The block checks the request against the drive capacity. It then cuts the request into chunks of at most `cfg_max_sect` sectors. For each chunk it translates the block number into cylinder, head and sector with a shared iterative divider, and sends a packed six-byte command over a byte-wide valid/ready stream.

After each command the block waits for the executing side to report success or failure. On success it advances the block number, the remaining count and the buffer address, then issues the next chunk. On failure it abandons the rest of the request. Each chunk also carries a flag that tells the executor to use programmed transfers rather than direct memory access when the chunk's buffer span crosses a 64 KiB boundary.

Top module: `disk_cmd_gen`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `cmd_valid`, `req_done` and `req_err` are all low.
- R2: A request is accepted only while `busy` is low. Once accepted, `busy` stays high until the cycle `req_done` pulses, and `req_valid` seen while `busy` is high has no effect on the request in flight.
- R3: If `req_block + req_count` is greater than `geo_heads * geo_cyls * geo_spt`, the request is rejected. `req_done` and `req_err` pulse together one cycle after the request is taken, no command byte is sent, and `busy` stays low.
- R4: A request with a count of zero that fits the capacity completes with a `req_done` pulse, without `req_err` and without any command.
- R5: Each chunk covers min(remaining count, `cfg_max_sect`) sectors. After `xfer_done`, the block number advances by the chunk size and the remaining count drops by the same amount. `req_done` without `req_err` pulses after the final chunk's `xfer_done`.
- R6: For a chunk starting at block B: track = B / spt, sector = B mod spt, head = track mod heads, cylinder = track / heads.
- R7: The command bytes are sent in this order:
  - byte 0 is the opcode, 0x08 for a read and 0x0A for a write (`req_write` = 1);
  - byte 1 is {drive[2:0], head[4:0]};
  - byte 2 is {cylinder[9:8], sector[5:0]};
  - byte 3 is cylinder[7:0];
  - byte 4 is the chunk sector count;
  - byte 5 is `geo_ctrl`.
- R8: A byte is transferred on a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_valid` is high and `cmd_ready` low, `cmd_data` holds steady. `cmd_last` is high exactly on byte 5.
- R9: An `xfer_fail` pulse while a chunk is outstanding ends the request. `req_done` and `req_err` pulse together in the next cycle, `busy` drops, and no further command is sent.
- R10: `cmd_pio` is high during a command when bits [ADDR_W-1:16] of the chunk's buffer address differ from those of that address plus 512 × chunk count. The buffer address advances by 512 bytes per sector after each successful chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | 3 | Drive number |
| req_block | input | BLK_W | Start block |
| req_count | input | CNT_W | Sector count |
| req_addr | input | ADDR_W | Buffer start address |
| geo_heads | input | 5 | Head count |
| geo_cyls | input | 10 | Cylinder count |
| geo_spt | input | 6 | Sectors per track |
| geo_ctrl | input | 8 | Per-drive control byte |
| cfg_max_sect | input | 8 | Largest chunk in sectors (nonzero) |
| busy | output | 1 | Request in flight |
| cmd_valid | output | 1 | Command byte valid |
| cmd_ready | input | 1 | Command byte accepted |
| cmd_data | output | 8 | Command byte |
| cmd_last | output | 1 | Marks byte 5 |
| cmd_pio | output | 1 | Chunk must use programmed transfer |
| xfer_done | input | 1 | Chunk finished pulse |
| xfer_fail | input | 1 | Chunk failed pulse |
| req_done | output | 1 | Request finished pulse |
| req_err | output | 1 | Request failed or rejected pulse |

## Verification
The bench targets these corner cases, and for each the effect of a wrong design:
- **Capacity edge.** A request that ends exactly at the last sector is accepted, and one a sector further is rejected. An off-by-one capacity compare either rejects a legal request or sends a command past the disk end.
- **Cylinder above 255.** The bench uses a cylinder number above 255. A packing fault in the shared byte 2 would drop or shift the two high cylinder bits onto the sector field.
- **Failure on a later chunk.** The bench fails a chunk after the first. A design that kept going would send an extra command, or would report done without error.
- **Buffer ending exactly on a 64 KiB line.** This case must flag programmed mode.
- **Back-pressure and stray requests.** Random back-pressure and stray `req_valid` pulses mid-request check that bytes hold steady and that latched request fields are never overwritten.

// File: rtl/dcg_pkg.sv
// Package: shared widths, opcodes, FSM encoding and command field layout
// for the disk request command-block generator.
package dcg_pkg;

    localparam int HEAD_W = 5;
    localparam int SECT_W = 6;
    localparam int CYL_W  = 10;
    localparam int DRV_W  = 3;
    localparam int CMD_BYTES = 6;

    localparam logic [7:0] OP_READ  = 8'h08;
    localparam logic [7:0] OP_WRITE = 8'h0A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_SEC,
        ST_WAIT_SEC,
        ST_DIV_HEAD,
        ST_WAIT_HEAD,
        ST_LOAD,
        ST_SEND,
        ST_WAIT_XFER
    } gen_state_t;

    typedef struct packed {
        logic [7:0]        opcode;
        logic [DRV_W-1:0]  drive;
        logic [HEAD_W-1:0] head;
        logic [CYL_W-1:0]  cyl;
        logic [SECT_W-1:0] sector;
        logic [7:0]        count;
        logic [7:0]        ctrl;
    } cmd_fields_t;

    // Returns command byte number idx of the packed block.
    function automatic logic [7:0] field_byte(cmd_fields_t f, logic [2:0] idx);
        case (idx)
            3'd0:    field_byte = f.opcode;
            3'd1:    field_byte = {f.drive, f.head};
            3'd2:    field_byte = {f.cyl[9:8], f.sector};
            3'd3:    field_byte = f.cyl[7:0];
            3'd4:    field_byte = f.count;
            default: field_byte = f.ctrl;
        endcase
    endfunction

endpackage

// File: rtl/dcg_divider.sv
// Module: dcg_divider
// Restoring divider that produces one quotient bit per cycle.
// A start pulse latches the dividend and divisor. Exactly DIVIDEND_W
// cycles later, done pulses with the quotient and remainder.
// Assumes a nonzero divisor; the parent rules out a zero divisor.
module dcg_divider #(
    parameter int DIVIDEND_W = 21,
    parameter int DIVISOR_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DIVIDEND_W-1:0] dividend,
    input  logic [DIVISOR_W-1:0]  divisor,
    output logic                  done,
    output logic [DIVIDEND_W-1:0] quotient,
    output logic [DIVISOR_W-1:0]  remainder
);
    localparam int STEP_W = $clog2(DIVIDEND_W + 1);

    logic [DIVISOR_W-1:0] div_q;
    logic [STEP_W-1:0]    steps;
    logic                 running;
    logic [DIVISOR_W:0]   trial;
    logic [DIVISOR_W:0]   diff;
    logic                 fits;

    // Shift the next dividend bit into the partial remainder and test it.
    always_comb begin
        trial = {remainder, quotient[DIVIDEND_W-1]};
        diff  = trial - {1'b0, div_q};
        fits  = (trial >= {1'b0, div_q});
    end

    // One restoring step per cycle, with a done pulse after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            steps     <= '0;
            running   <= 1'b0;
            done      <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                div_q     <= divisor;
                quotient  <= dividend;
                remainder <= '0;
                steps     <= STEP_W'(DIVIDEND_W);
                running   <= 1'b1;
            end else if (running) begin
                quotient  <= {quotient[DIVIDEND_W-2:0], fits};
                remainder <= fits ? diff[DIVISOR_W-1:0] : trial[DIVISOR_W-1:0];
                steps     <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    AST_DIV_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_q != '0) |-> (remainder < div_q)); // R6
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

endmodule

// File: rtl/dcg_cmd_packer.sv
// Module: dcg_cmd_packer
// Holds one command's fields and sends its six bytes in order over a
// valid/ready byte stream. cmd_last marks the final byte. sent pulses the
// cycle after the final byte is accepted. load is only given while idle.
module dcg_cmd_packer
    import dcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  cmd_fields_t fields,
    input  logic        pio_in,
    input  logic        cmd_ready,
    output logic        cmd_valid,
    output logic [7:0]  cmd_data,
    output logic        cmd_last,
    output logic        cmd_pio,
    output logic        sent
);
    localparam logic [2:0] LAST_IDX = 3'(CMD_BYTES - 1);

    cmd_fields_t fields_q;
    logic [2:0]  idx;

    // Select the current byte from the held fields.
    always_comb begin
        cmd_data = field_byte(fields_q, idx);
        cmd_last = cmd_valid && (idx == LAST_IDX);
    end

    // Load a command, then step the byte index on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q  <= '0;
            idx       <= '0;
            cmd_valid <= 1'b0;
            cmd_pio   <= 1'b0;
            sent      <= 1'b0;
        end else begin
            sent <= 1'b0;
            if (load) begin
                fields_q  <= fields;
                cmd_pio   <= pio_in;
                idx       <= '0;
                cmd_valid <= 1'b1;
            end else if (cmd_valid && cmd_ready) begin
                if (idx == LAST_IDX) begin
                    cmd_valid <= 1'b0;
                    sent      <= 1'b1;
                end else begin
                    idx <= idx + 3'd1;
                end
            end
        end
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !load) |=> (cmd_valid && $stable(cmd_data))); // R8
    AST_SENT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_last && cmd_ready) |=> sent); // R8

endmodule

// File: rtl/disk_cmd_gen.sv
// Module: disk_cmd_gen
// Takes a linear block request, checks it against the drive capacity,
// splits it into chunks of at most cfg_max_sect sectors, and for each
// chunk translates the block number to cylinder/head/sector and sends a
// six-byte command. It then waits for xfer_done or xfer_fail.
// Assumes geometry, geo_ctrl and cfg_max_sect stay stable while busy,
// cfg_max_sect is nonzero, CNT_W >= 8, BLK_W >= 10 and ADDR_W >= 17.
module disk_cmd_gen
    import dcg_pkg::*;
#(
    parameter int BLK_W  = 21,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DRV_W-1:0]  req_drive,
    input  logic [BLK_W-1:0]  req_block,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HEAD_W-1:0] geo_heads,
    input  logic [CYL_W-1:0]  geo_cyls,
    input  logic [SECT_W-1:0] geo_spt,
    input  logic [7:0]        geo_ctrl,
    input  logic [7:0]        cfg_max_sect,
    output logic              busy,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_data,
    output logic              cmd_last,
    output logic              cmd_pio,
    input  logic              xfer_done,
    input  logic              xfer_fail,
    output logic              req_done,
    output logic              req_err
);
    localparam int CAP_W = HEAD_W + CYL_W + SECT_W;
    localparam int SUM_W = ((BLK_W > CNT_W) ? BLK_W : CNT_W) + 1;
    localparam int CMP_W = (SUM_W > CAP_W) ? SUM_W : CAP_W;

    gen_state_t          state;
    logic                write_q;
    logic [DRV_W-1:0]    drive_q;
    logic [BLK_W-1:0]    block_q;
    logic [CNT_W-1:0]    remain_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [7:0]          chunk_q;
    logic [SECT_W-1:0]   sector_q;
    logic [SECT_W-1:0]   head_full_q;
    logic [BLK_W-1:0]    track_q;
    logic [BLK_W-1:0]    cyl_full_q;

    logic [CAP_W-1:0]    capacity;
    logic                over_cap;
    logic [7:0]          chunk_next;
    logic [ADDR_W-1:0]   chunk_bytes;
    logic [ADDR_W-1:0]   end_addr;
    logic                pio_calc;

    logic                div_start;
    logic [BLK_W-1:0]    div_dividend;
    logic [SECT_W-1:0]   div_divisor;
    logic                div_done;
    logic [BLK_W-1:0]    div_quo;
    logic [SECT_W-1:0]   div_rem;

    cmd_fields_t         fields;
    logic                pack_load;
    logic                pack_sent;

    // Capacity check and chunk sizing.
    always_comb begin
        capacity   = CAP_W'(geo_heads) * CAP_W'(geo_cyls) * CAP_W'(geo_spt);
        over_cap   = (CMP_W'(req_block) + CMP_W'(req_count)) > CMP_W'(capacity);
        chunk_next = (remain_q < CNT_W'(cfg_max_sect)) ? remain_q[7:0] : cfg_max_sect;
    end

    // Buffer span of the current chunk and the 64 KiB crossing test.
    always_comb begin
        chunk_bytes = ADDR_W'({chunk_q, 9'b0});
        end_addr    = addr_q + chunk_bytes;
        pio_calc    = (addr_q[ADDR_W-1:16] != end_addr[ADDR_W-1:16]);
    end

    // Share the divider: block/spt first, then track/heads.
    always_comb begin
        div_start    = (state == ST_DIV_SEC) || (state == ST_DIV_HEAD);
        div_dividend = (state == ST_DIV_HEAD) ? track_q : block_q;
        div_divisor  = (state == ST_DIV_HEAD) ? SECT_W'(geo_heads) : geo_spt;
    end

    // Build the command fields from the translated address.
    always_comb begin
        fields.opcode = write_q ? OP_WRITE : OP_READ;
        fields.drive  = drive_q;
        fields.head   = head_full_q[HEAD_W-1:0];
        fields.cyl    = cyl_full_q[CYL_W-1:0];
        fields.sector = sector_q;
        fields.count  = chunk_q;
        fields.ctrl   = geo_ctrl;
        pack_load     = (state == ST_LOAD);
        busy          = (state != ST_IDLE);
    end

    dcg_divider #(
        .DIVIDEND_W (BLK_W),
        .DIVISOR_W  (SECT_W)
    ) divider_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (div_dividend),
        .divisor   (div_divisor),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    dcg_cmd_packer packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pack_load),
        .fields    (fields),
        .pio_in    (pio_calc),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_last  (cmd_last),
        .cmd_pio   (cmd_pio),
        .sent      (pack_sent)
    );

    // Request sequencing: accept, translate, send, await result, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            write_q     <= 1'b0;
            drive_q     <= '0;
            block_q     <= '0;
            remain_q    <= '0;
            addr_q      <= '0;
            chunk_q     <= '0;
            sector_q    <= '0;
            head_full_q <= '0;
            track_q     <= '0;
            cyl_full_q  <= '0;
            req_done    <= 1'b0;
            req_err     <= 1'b0;
        end else begin
            req_done <= 1'b0;
            req_err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (over_cap) begin
                            req_done <= 1'b1;
                            req_err  <= 1'b1;
                        end else if (req_count == '0) begin
                            req_done <= 1'b1;
                        end else begin
                            write_q  <= req_write;
                            drive_q  <= req_drive;
                            block_q  <= req_block;
                            remain_q <= req_count;
                            addr_q   <= req_addr;
                            state    <= ST_DIV_SEC;
                        end
                    end
                end
                ST_DIV_SEC: begin
                    chunk_q <= chunk_next;
                    state   <= ST_WAIT_SEC;
                end
                ST_WAIT_SEC: begin
                    if (div_done) begin
                        sector_q <= div_rem;
                        track_q  <= div_quo;
                        state    <= ST_DIV_HEAD;
                    end
                end
                ST_DIV_HEAD: state <= ST_WAIT_HEAD;
                ST_WAIT_HEAD: begin
                    if (div_done) begin
                        head_full_q <= div_rem;
                        cyl_full_q  <= div_quo;
                        state       <= ST_LOAD;
                    end
                end
                ST_LOAD: state <= ST_SEND;
                ST_SEND: begin
                    if (pack_sent) state <= ST_WAIT_XFER;
                end
                ST_WAIT_XFER: begin
                    if (xfer_fail) begin
                        req_done <= 1'b1;
                        req_err  <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (xfer_done) begin
                        block_q  <= block_q + BLK_W'(chunk_q);
                        remain_q <= remain_q - CNT_W'(chunk_q);
                        addr_q   <= end_addr;
                        if (remain_q == CNT_W'(chunk_q)) begin
                            req_done <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            state <= ST_DIV_SEC;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid); // R2
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !busy); // R2
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done); // R9
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (chunk_q != 8'd0 && chunk_q <= cfg_max_sect
                                && CNT_W'(chunk_q) <= remain_q)); // R5
    AST_HEAD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (head_full_q < SECT_W'(geo_heads)
                                && sector_q < geo_spt)); // R6
    AST_CYL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (cyl_full_q < BLK_W'(geo_cyls))); // R6

endmodule

// File: tb/disk_cmd_gen_tb.sv
// Testbench: directed corner cases plus seeded random requests, checked
// against expected command bytes computed from the requirements.
module disk_cmd_gen_tb_top;

    localparam int BLK_W  = 21;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 20;
    localparam longint ADDR_MASK = (64'd1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [2:0]        req_drive = '0;
    logic [BLK_W-1:0]  req_block = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [4:0]        geo_heads = 5'd4;
    logic [9:0]        geo_cyls = 10'd600;
    logic [5:0]        geo_spt = 6'd17;
    logic [7:0]        geo_ctrl = 8'h05;
    logic [7:0]        cfg_max_sect = 8'd1;
    logic              busy;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [7:0]        cmd_data;
    logic              cmd_last;
    logic              cmd_pio;
    logic              xfer_done = 1'b0;
    logic              xfer_fail = 1'b0;
    logic              req_done;
    logic              req_err;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    disk_cmd_gen #(.BLK_W(BLK_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_drive(req_drive), .req_block(req_block), .req_count(req_count),
        .req_addr(req_addr), .geo_heads(geo_heads), .geo_cyls(geo_cyls),
        .geo_spt(geo_spt), .geo_ctrl(geo_ctrl), .cfg_max_sect(cfg_max_sect),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_pio(cmd_pio),
        .xfer_done(xfer_done), .xfer_fail(xfer_fail),
        .req_done(req_done), .req_err(req_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic longint capacity();
        return longint'(geo_heads) * longint'(geo_cyls) * longint'(geo_spt);
    endfunction

    // Expected command byte k for a chunk (R6, R7).
    function automatic logic [7:0] exp_byte(input int k, input bit wr, input int drv,
                                            input longint blk, input int ch);
        longint trk, sec, hd, cyl;
        trk = blk / geo_spt;
        sec = blk % geo_spt;
        hd  = trk % geo_heads;
        cyl = trk / geo_heads;
        case (k)
            0: return wr ? 8'h0A : 8'h08;
            1: return 8'((drv << 5) | hd);
            2: return 8'((((cyl >> 8) & 3) << 6) | sec);
            3: return 8'(cyl & 255);
            4: return 8'(ch & 255);
            default: return geo_ctrl;
        endcase
    endfunction

    task automatic run_req(input bit wr, input int drv, input longint blk, input int cnt,
                           input longint addr, input int max_s, input int fail_chunk);
        longint cap, cb, ca;
        int remaining, ch, ci, idx, tmo;
        bit hold_pend, exp_pio;
        logic [7:0] held;
        logic [7:0] got [6];
        cap = capacity();
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_drive = 3'(drv);
        req_block = BLK_W'(blk); req_count = CNT_W'(cnt);
        req_addr = ADDR_W'(addr); cfg_max_sect = 8'(max_s);
        @(negedge clk);
        req_valid = 1'b0;
        if (blk + cnt > cap || cnt == 0) begin
            if (blk + cnt > cap) begin
                chk(req_done && req_err, "R3 reject done+err", {req_done, req_err}, 2'b11);
                chk(!busy, "R3 busy stays low", busy, 0);
            end else begin
                chk(req_done && !req_err, "R4 zero count done", {req_done, req_err}, 2'b10);
            end
            for (int w = 0; w < 60; w++) begin
                @(negedge clk);
                if (cmd_valid) chk(0, "R3 R4 no command", cmd_valid, 0);
            end
            return;
        end
        chk(busy && !req_done, "R2 busy after accept", busy, 1);
        remaining = cnt; cb = blk; ca = addr; ci = 0;
        while (remaining > 0) begin
            ch = (remaining < max_s) ? remaining : max_s;
            exp_pio = ((ca >> 16) != (((ca + ch * 512) & ADDR_MASK) >> 16));
            idx = 0; tmo = 0; hold_pend = 0; held = '0;
            while (idx < 6 && tmo < 3000) begin
                @(negedge clk);
                tmo++;
                // R2: stray request pulse while busy must be ignored
                req_valid = (tmo == 3);
                if (tmo == 3) begin
                    req_block = BLK_W'($urandom); req_count = CNT_W'($urandom);
                    req_write = ~wr; req_drive = 3'($urandom);
                end
                if (hold_pend)
                    chk(cmd_valid && cmd_data == held, "R8 byte held under back-pressure", cmd_data, held);
                hold_pend = 0;
                cmd_ready = ($urandom % 4) != 0;
                if (cmd_valid) begin
                    if (cmd_ready) begin
                        got[idx] = cmd_data;
                        if (idx == 0) chk(cmd_pio == exp_pio, "R10 pio flag", cmd_pio, exp_pio);
                        chk(cmd_last == (idx == 5), "R8 last marker", cmd_last, idx == 5);
                        idx++;
                    end else begin
                        hold_pend = 1; held = cmd_data;
                    end
                end
            end
            @(negedge clk);
            cmd_ready = 1'b0; req_valid = 1'b0;
            if (idx < 6) begin
                chk(0, "R5 command missing", idx, 6);
                return;
            end
            chk(got[0] == exp_byte(0, wr, drv, cb, ch), "R7 opcode", got[0], exp_byte(0, wr, drv, cb, ch));
            chk(got[1] == exp_byte(1, wr, drv, cb, ch), "R6 drive/head byte", got[1], exp_byte(1, wr, drv, cb, ch));
            chk(got[2] == exp_byte(2, wr, drv, cb, ch), "R6 cyl-high/sector byte", got[2], exp_byte(2, wr, drv, cb, ch));
            chk(got[3] == exp_byte(3, wr, drv, cb, ch), "R6 cyl-low byte", got[3], exp_byte(3, wr, drv, cb, ch));
            chk(got[4] == exp_byte(4, wr, drv, cb, ch), "R5 chunk count", got[4], exp_byte(4, wr, drv, cb, ch));
            chk(got[5] == exp_byte(5, wr, drv, cb, ch), "R7 control byte", got[5], exp_byte(5, wr, drv, cb, ch));
            repeat (1 + $urandom % 3) @(negedge clk);
            chk(busy && !req_done, "R2 busy while chunk outstanding", busy, 1);
            if (ci == fail_chunk) xfer_fail = 1'b1; else xfer_done = 1'b1;
            @(negedge clk);
            xfer_fail = 1'b0; xfer_done = 1'b0;
            if (ci == fail_chunk) begin
                chk(req_done && req_err, "R9 fail ends request", {req_done, req_err}, 2'b11);
                chk(!busy, "R9 busy drops", busy, 0);
                for (int w = 0; w < 80; w++) begin
                    @(negedge clk);
                    if (cmd_valid) chk(0, "R9 no command after fail", cmd_valid, 0);
                end
                return;
            end
            if (remaining == ch) begin
                chk(req_done && !req_err, "R5 done after last chunk", {req_done, req_err}, 2'b10);
                chk(!busy, "R2 idle after done", busy, 0);
            end else begin
                chk(!req_done, "R5 no early done", req_done, 0);
            end
            remaining -= ch; cb += ch; ca = (ca + ch * 512) & ADDR_MASK; ci++;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        longint cap, blk;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(!busy && !cmd_valid && !req_done && !req_err, "R1 reset state",
            {busy, cmd_valid, req_done, req_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_valid, "R1 idle after reset", {busy, cmd_valid}, 0);

        geo_heads = 5'd4; geo_cyls = 10'd600; geo_spt = 6'd17; geo_ctrl = 8'h05;
        cap = capacity();
        run_req(0, 0, 0, 1, 20'h01000, 1, -1);
        run_req(1, 1, cap - 3, 3, 20'h02000, 2, -1);   // R3 exact capacity edge accepted
        run_req(0, 2, cap - 2, 3, 20'h02000, 2, -1);   // R3 one past capacity rejected
        run_req(0, 0, 5, 0, 0, 1, -1);                 // R4 zero count
        run_req(1, 3, 100, 5, 20'h04000, 2, 1);        // R9 fail on second chunk
        run_req(0, 0, 30, 1, 20'h0FE00, 1, -1);        // R10 ends exactly on 64 KiB line
        run_req(0, 0, 40, 4, 20'h00000, 4, -1);        // R10 no crossing
        run_req(1, 5, 50, 7, 20'h1F600, 3, -1);        // R10 crossing on a later chunk
        geo_heads = 5'd0;
        run_req(0, 0, 0, 1, 0, 1, -1);                 // R3 zero heads gives zero capacity
        geo_heads = 5'd2; geo_cyls = 10'd1000; geo_spt = 6'd17;
        run_req(0, 7, (677 * 2 + 1) * 17 + 5, 2, 20'h30000, 8, -1); // R6 cylinder above 255

        for (int it = 0; it < 40; it++) begin
            geo_heads = 5'(1 + $urandom % 16);
            geo_spt   = 6'(1 + $urandom % 63);
            geo_cyls  = 10'(1 + $urandom % 1023);
            geo_ctrl  = 8'($urandom);
            cap = capacity();
            blk = longint'($urandom) % cap;
            run_req(1'($urandom), int'($urandom % 8), blk, int'(1 + $urandom % 12),
                    longint'($urandom) & ADDR_MASK, int'(1 + $urandom % 5),
                    ($urandom % 4 == 0) ? int'($urandom % 3) : -1);
        end

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule